// File: doc/BRIEF.md
# Flash Busy Status Reporter

This block reproduces what a parallel NOR flash puts on its data bus while an internal program or erase is running. A one-cycle start pulse launches an operation. The pulse carries the operation kind and the data byte that was last loaded. A cycle counter then keeps the block busy for a programmable number of clocks. The count is set separately for byte programs and for erases.

The host reads by pulling both the chip-enable and output-enable strobes low. While the block is busy, each read returns a status byte instead of array data. Bit 7 of the status byte is a polling bit that depends on the operation kind. Bit 6 flips on every new read. Once the counter expires, the block raises a one-clock done pulse and reads pass the array data input through unchanged.

The block sits beside a flash array model and its command decoder. It owns only the busy timing, the toggle state and the selection of the byte that goes onto the data bus.

Top module: `flash_busy_status`

## Requirements
- R1: While rst_n is low, busy, done and dout are all 0.
- R2: A start pulse taken while idle raises busy on the next cycle. Busy then stays high for exactly PROG_CYCLES cycles when op_kind is 2'b00 (byte program), or ERASE_CYCLES cycles for any other op_kind (2'b01 block erase, 2'b10 chip erase, 2'b11 treated as an erase).
- R3: done is high for exactly one cycle, namely the first cycle in which busy is low again after an operation.
- R4: A start pulse that arrives while busy, including during a chip erase, is ignored. It changes neither the remaining busy time nor the operation kind and data that drive the status byte.
- R5: A read is active in a cycle where both ce_n and oe_n are low. A new read begins when the read becomes active after a cycle in which it was not, so toggling either strobe or both starts a new read. dout is registered: it reflects the read state and data of the previous cycle, and it is 8'h00 when no read was active.
- R6: During a byte program, bit 7 of every read returns the inverse of bit 7 of the loaded byte.
- R7: During a block or chip erase, bit 7 of every read returns 0.
- R8: Bit 6 of the status byte is cleared when an operation starts. It flips at the start of each new read while busy, so the first read of an operation returns 1 and the next returns 0. It does not flip while idle.
- R9: During busy, bits 5 down to 0 of every read are 0.
- R10: While idle, a read returns all eight bits of array_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches an operation |
| op_kind | input | 2 | 00 program, 01 block erase, 10 chip erase, 11 erase |
| load_data | input | 8 | Last loaded data byte of the operation |
| ce_n | input | 1 | Chip-enable strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| array_rdata | input | 8 | True array data for idle reads |
| dout | output | 8 | Registered read data or status byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when an operation ends |

## Verification
The bench builds the block with PROG_CYCLES of 6 and ERASE_CYCLES of 11, instead of the hundreds and millions of cycles used in real timing. With these values, hundreds of complete program and erase operations fit into a short run. That brings several cases within reach many times over: the last-cycle boundary where busy drops while a read is in flight, starts landing on every cycle of an operation in progress, and a long chain of toggle flips. The two lengths differ, so a wrong choice of length between program and erase shows up as a shifted done pulse.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    typedef enum logic [1:0] {
        OP_PROG       = 2'b00,
        OP_BLK_ERASE  = 2'b01,
        OP_CHIP_ERASE = 2'b10,
        OP_ERASE_ALT  = 2'b11
    } op_e;

    function automatic logic op_is_prog(input logic [1:0] op);
        return op == OP_PROG;
    endfunction

endpackage

// File: rtl/fbs_timer.sv
module fbs_timer #(
    parameter int PROG_CYCLES  = 750,
    parameter int ERASE_CYCLES = 2000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] op_i,
    input  logic       data7_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       prog_o,
    output logic       d7_o,
    output logic       launch_o
);
    import fbs_pkg::*;

    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          prog;
        logic          d7;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic launch;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        launch   = start_i && !s_q.busy;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (launch) begin
            s_d.busy = 1'b1;
            s_d.prog = op_is_prog(op_i);
            s_d.d7   = data7_i;
            s_d.cnt  = op_is_prog(op_i) ? PROG_LOAD : ERASE_LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o   = s_q.busy;
    assign done_o   = s_q.done;
    assign prog_o   = s_q.prog;
    assign d7_o     = s_q.d7;
    assign launch_o = launch;

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> !s_q.busy && $past(s_q.busy));
    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> s_q.busy && (s_q.cnt == $past(s_q.cnt) - 1'b1));
    a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i) |=> $stable(s_q.prog) && $stable(s_q.d7));

endmodule

// File: rtl/fbs_rd_detect.sv
module fbs_rd_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic oe_n_i,
    output logic rd_o,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } rd_t;

    rd_t s_d, s_q;
    logic rd_now;

    always_comb begin
        rd_now    = !ce_n_i && !oe_n_i;
        s_d.prev  = rd_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_o   = rd_now;
    assign rise_o = rd_now && !s_q.prev;

endmodule

// File: rtl/fbs_status_mux.sv
module fbs_status_mux #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          clear_i,
    input  logic          rd_i,
    input  logic          rise_i,
    input  logic          prog_i,
    input  logic          d7_i,
    input  logic [DW-1:0] arr_i,
    output logic [DW-1:0] dout_o
);
    localparam int LOW_W = DW - 2;

    typedef struct packed {
        logic          tog;
        logic [DW-1:0] dout;
    } mux_t;

    mux_t s_d, s_q;
    logic poll_bit;

    always_comb begin
        s_d = s_q;
        if (clear_i)
            s_d.tog = 1'b0;
        else if (busy_i && rise_i)
            s_d.tog = !s_q.tog;
        poll_bit = prog_i ? !d7_i : 1'b0;
        if (!rd_i)
            s_d.dout = '0;
        else if (busy_i)
            s_d.dout = {poll_bit, s_d.tog, {LOW_W{1'b0}}};
        else
            s_d.dout = arr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout_o = s_q.dout;

    a_r5_no_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> s_q.dout == '0);
    a_r9_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_i) |=> s_q.dout[LOW_W-1:0] == '0);
    a_r6_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_i && prog_i) |=> s_q.dout[DW-1] == !$past(d7_i));
    a_r7_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_i && !prog_i) |=> !s_q.dout[DW-1]);
    a_r10_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && rd_i) |=> s_q.dout == $past(arr_i));
    a_r8_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rise_i) |=> s_q.tog != $past(s_q.tog));

endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status #(
    parameter int PROG_CYCLES  = 750,
    parameter int ERASE_CYCLES = 2000000,
    parameter int DW           = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_kind,
    input  logic [DW-1:0] load_data,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [DW-1:0] array_rdata,
    output logic [DW-1:0] dout,
    output logic          busy,
    output logic          done
);
    logic prog, d7, launch, rd, rise;

    fbs_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .op_i    (op_kind),
        .data7_i (load_data[DW-1]),
        .busy_o  (busy),
        .done_o  (done),
        .prog_o  (prog),
        .d7_o    (d7),
        .launch_o(launch)
    );

    fbs_rd_detect u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n_i(ce_n),
        .oe_n_i(oe_n),
        .rd_o  (rd),
        .rise_o(rise)
    );

    fbs_status_mux #(.DW(DW)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy),
        .clear_i(launch),
        .rd_i   (rd),
        .rise_i (rise),
        .prog_i (prog),
        .d7_i   (d7),
        .arr_i  (array_rdata),
        .dout_o (dout)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && dout == '0);

endmodule

// File: tb/flash_busy_status_tb.sv
module flash_busy_status_tb;
    localparam int PC = 6;
    localparam int EC = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op_kind = 2'b00;
    logic [7:0] load_data = 8'h00;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [7:0] array_rdata = 8'h00;
    logic [7:0] dout;
    logic       busy, done;

    always #10 clk = ~clk;

    flash_busy_status #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .load_data(load_data), .ce_n(ce_n), .oe_n(oe_n),
        .array_rdata(array_rdata), .dout(dout), .busy(busy), .done(done)
    );

    int n_run = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // expected behaviour built from the requirements
    logic m_busy = 0, m_done = 0, m_prog = 0, m_d7 = 0, m_tog = 0, m_rdp = 0, m_ign = 0;
    logic m_rd_at = 0, m_busy_at = 0, m_prog_at = 0;
    int   m_left = 0;
    logic [7:0] m_dout = 8'h00;

    function automatic logic [7:0] status_byte(input logic prog, input logic d7, input logic tog);
        return {prog ? ~d7 : 1'b0, tog, 6'b0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_tog = 0; m_rdp = 0; m_ign = 0;
            m_rd_at = 0; m_busy_at = 0; m_dout = 8'h00; m_left = 0;
        end else begin
            logic rd, nt, take;
            rd   = !ce_n && !oe_n;
            take = start && !m_busy;
            nt   = take ? 1'b0 : (m_busy && rd && !m_rdp) ? ~m_tog : m_tog;
            m_rd_at = rd; m_busy_at = m_busy; m_prog_at = m_prog;
            m_dout = !rd ? 8'h00 : m_busy ? status_byte(m_prog, m_d7, nt) : array_rdata;
            m_tog = nt;
            m_rdp = rd;
            m_done = 0;
            if (m_busy) begin
                if (start) m_ign = 1;
                m_left--;
                if (m_left == 0) begin m_busy = 0; m_done = 1; end
            end else if (take) begin
                m_busy = 1; m_ign = 0;
                m_prog = (op_kind == 2'b00);
                m_d7 = load_data[7];
                m_left = m_prog ? PC : EC;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(m_ign ? "R4" : "R2", "busy", {7'b0, busy}, {7'b0, m_busy});
            chk("R3", "done", {7'b0, done}, {7'b0, m_done});
            if (!m_rd_at)
                chk("R5", "dout idle bus", dout, 8'h00);
            else if (m_busy_at) begin
                chk(m_prog_at ? "R6" : "R7", "poll bit", {7'b0, dout[7]}, {7'b0, m_dout[7]});
                chk("R8", "toggle bit", {7'b0, dout[6]}, {7'b0, m_dout[6]});
                chk("R9", "low bits", {2'b0, dout[5:0]}, 8'h00);
            end else
                chk("R10", "array data", dout, m_dout);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic launch(input logic [1:0] op, input logic [7:0] d);
        start = 1'b1; op_kind = op; load_data = d;
        step();
        start = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        start = 1'b1; ce_n = 1'b0; oe_n = 1'b0; array_rdata = 8'hA5;
        repeat (3) step();
        chk("R1", "busy in reset", {7'b0, busy}, 8'h00);
        chk("R1", "done in reset", {7'b0, done}, 8'h00);
        chk("R1", "dout in reset", dout, 8'h00);
        start = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        rst_n = 1'b1;
        step();

        // R6 program with data bit7 set, reads by toggling oe_n
        ce_n = 1'b0;
        launch(2'b00, 8'h80);
        for (int i = 0; i < 6; i++) begin oe_n = 1'b0; step(); oe_n = 1'b1; step(); end
        ce_n = 1'b1; repeat (3) step();

        // R6 program with data bit7 clear, reads by toggling ce_n
        oe_n = 1'b0;
        launch(2'b00, 8'h35);
        for (int i = 0; i < 6; i++) begin ce_n = 1'b0; step(); step(); ce_n = 1'b1; step(); end
        oe_n = 1'b1; repeat (3) step();

        // R7 block erase, both strobes toggled together
        launch(2'b01, 8'h00);
        for (int i = 0; i < 8; i++) begin ce_n = 1'b0; oe_n = 1'b0; step(); ce_n = 1'b1; oe_n = 1'b1; step(); end
        repeat (3) step();

        // R4 chip erase, start attempts in the middle, held read
        launch(2'b10, 8'hFF);
        ce_n = 1'b0; oe_n = 1'b0;
        step(); step();
        launch(2'b00, 8'h00);
        step();
        launch(2'b01, 8'h12);
        array_rdata = 8'hFF;
        repeat (12) step();
        ce_n = 1'b1; oe_n = 1'b1; step();

        // R10 idle reads with varying data
        for (int i = 0; i < 6; i++) begin
            array_rdata = 8'h11 * i[7:0] ^ 8'h5A;
            ce_n = 1'b0; oe_n = 1'b0; step();
            ce_n = i[0]; step();
        end
        ce_n = 1'b1; oe_n = 1'b1; step();

        // random mix
        for (int i = 0; i < 4000; i++) begin
            start = ($urandom % 12) == 0;
            op_kind = 2'($urandom);
            load_data = 8'($urandom);
            array_rdata = 8'($urandom);
            ce_n = ($urandom % 3) == 0;
            oe_n = ($urandom % 3) == 0;
            step();
        end
        start = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        repeat (20) step();
        summary();
    end
endmodule